// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block is a helper on the controller side of a two-wire serial bus. It frees a bus whose data line is held low by a target that lost its place in a transfer, for example after a reset in the middle of a read. A one-cycle trigger starts a burst of clock pulses on the clock line. At the end of each clock-high phase the block looks at the data line. When a pulse finds the data line released, the block places a start condition on the bus, parks both lines low, releases data and then clock, and reports success. When the data line is still low after the last allowed pulse, the block releases both lines and reports failure.

Both outputs are pull-low requests for open-drain pads. The block never drives a line high. Phase lengths come from a divider of the system clock that is set by a parameter. The data line input passes through a synchronizer before it is used. The block does not move data. Its job ends once the bus is back in a known state.

Top module: `bus_recovery_seq`

## Requirements
- R1: In idle, a high `start_i` on a clock edge begins recovery in that edge. `scl_pull_o` is then 1 for HALF_CYC cycles, then 0 for HALF_CYC cycles, and this low-then-high pattern makes one pulse.
- R2: One recovery issues no more than MAX_PULSES (default 9) clock-high phases on `scl_pull_o`.
- R3: `sda_i` (1 = line high) is sampled after SYNC_STAGES flops, at the last cycle of each clock-high phase. If the sample is 1, `sda_pull_o` goes to 1 while `scl_pull_o` stays 0 (start condition). It holds that way for HALF_CYC cycles before `scl_pull_o` returns to 1.
- R4: After the start condition, both pulls are 1 for HALF_CYC cycles. Then `sda_pull_o` drops to 0 with `scl_pull_o` still 1 for HALF_CYC cycles. Then `scl_pull_o` drops to 0 in the same cycle that `done_o` is 1. The number of clock-high phases before `done_o` equals the index of the first pulse that saw the line high.
- R5: Apart from the start condition, the data line never changes while the clock line is released.
- R6: If the sample at the end of pulse MAX_PULSES is 0, `fail_o` is 1 for one cycle, both pulls are 0, and no start condition is issued.
- R7: After reset, and in idle, both pulls and both flags are 0.
- R8: `start_i` has no effect while a recovery is in progress.
- R9: `done_o` and `fail_o` are single-cycle pulses, are never high together, and each recovery produces exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a recovery (idle only) |
| sda_i | input | 1 | Level seen on the data line, 1 = high |
| scl_pull_o | output | 1 | Pull the clock line low |
| sda_pull_o | output | 1 | Pull the data line low |
| done_o | output | 1 | One-cycle pulse: bus freed, start issued |
| fail_o | output | 1 | One-cycle pulse: data line still held |

## Verification
The hardest situation to reach is a target that lets go at exactly pulse MAX_PULSES, next to one that never lets go, because those two runs differ only in the final sample. The bench models a stuck target on the wired-AND bus. This target holds the data line low until a chosen number of clock falls has passed. It sweeps that number directly across 0, 1, the last success pulse and the first fail count, and draws further values at random with a fixed seed. Some runs also raise the trigger in the middle of a recovery, and the pulse count the bench measures shows whether the trigger restarted anything.

// File: rtl/rcv_pkg.sv
package rcv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOW   = 3'd1,
    ST_HIGH  = 3'd2,
    ST_START = 3'd3,
    ST_PARK  = 3'd4,
    ST_FREE  = 3'd5
  } rcv_state_e;

  // clock line is held low in these phases
  function automatic logic scl_low(rcv_state_e s);
    return (s == ST_LOW) || (s == ST_PARK) || (s == ST_FREE);
  endfunction

  // data line is held low only around the start condition
  function automatic logic sda_low(rcv_state_e s);
    return (s == ST_START) || (s == ST_PARK);
  endfunction

endpackage

// File: rtl/rcv_sync.sv
module rcv_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b1;
        else if (i == 0) ff_q[i] <= d_i;
        else ff_q[i] <= ff_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rcv_half_timer.sv
module rcv_half_timer #(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  a_r1_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r1_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/rcv_fsm.sv
module rcv_fsm
  import rcv_pkg::*;
#(
  parameter int unsigned MAX_PULSES = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_s_i,
  input  logic tick_i,
  output logic run_o,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic done_o,
  output logic fail_o
);
  localparam int unsigned PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PMAX = PW'(MAX_PULSES);

  rcv_state_e state_q, state_d;
  logic [PW-1:0] pulse_q, pulse_d;
  logic done_d, fail_d;
  logic scl_q, sda_q, done_q, fail_q;

  assign run_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    pulse_d = pulse_q;
    done_d  = 1'b0;
    fail_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_LOW;
        pulse_d = '0;
      end
      ST_LOW: if (tick_i) state_d = ST_HIGH;
      ST_HIGH: if (tick_i) begin
        pulse_d = pulse_q + 1'b1;
        if (sda_s_i) state_d = ST_START;
        else if (pulse_d == PMAX) begin
          state_d = ST_IDLE;
          fail_d  = 1'b1;
        end else state_d = ST_LOW;
      end
      ST_START: if (tick_i) state_d = ST_PARK;
      ST_PARK:  if (tick_i) state_d = ST_FREE;
      ST_FREE: if (tick_i) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= '0;
      scl_q   <= 1'b0;
      sda_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
      scl_q   <= scl_low(state_d);
      sda_q   <= sda_low(state_d);
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign scl_pull_o = scl_q;
  assign sda_pull_o = sda_q;
  assign done_o     = done_q;
  assign fail_o     = fail_q;

  a_r2_pulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q <= PMAX);
  a_r3_start_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_pull_o) && !scl_pull_o) |-> $past(sda_s_i));
  a_r5_sda_release_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_pull_o) |-> (scl_pull_o && $past(scl_pull_o)));
  a_r6_fail_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (!scl_pull_o && !sda_pull_o));
  a_r6_fail_saw_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !$past(sda_s_i));
  a_r8_busy_ignores_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && start_i && !tick_i) |=> ($stable(pulse_q) && $stable(state_q)));
  a_r9_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_fail_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);
endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq #(
  parameter int unsigned HALF_CYC    = 8,
  parameter int unsigned MAX_PULSES  = 9,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic done_o,
  output logic fail_o
);
  logic sda_s, tick, run;

  rcv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sda_i),
    .q_o   (sda_s)
  );

  rcv_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .tick_o(tick)
  );

  rcv_fsm #(.MAX_PULSES(MAX_PULSES)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .sda_s_i   (sda_s),
    .tick_i    (tick),
    .run_o     (run),
    .scl_pull_o(scl_pull_o),
    .sda_pull_o(sda_pull_o),
    .done_o    (done_o),
    .fail_o    (fail_o)
  );

  a_r7_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (!sda_pull_o && !done_o && !fail_o) || done_o || fail_o);
  a_r5_no_stop_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_pull_o && $past(!scl_pull_o)) |-> !$fell(sda_pull_o));
endmodule

// File: tb/bus_recovery_seq_test.sv
module bus_recovery_seq_test;
  localparam int HALF = 8;
  localparam int MAXP = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic scl_pull, sda_pull, done, fail;
  int   tgt_k = 0;
  int   falls_cnt = 0;
  int   total = 0;
  int   bad = 0;

  // stuck target holds data low until more than tgt_k clock falls have passed
  wire tgt_hold = (falls_cnt <= tgt_k);
  wire sda_line = !(sda_pull || tgt_hold);
  wire scl_line = !scl_pull;

  always #4 clk = ~clk;

  bus_recovery_seq #(.HALF_CYC(HALF), .MAX_PULSES(MAXP), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .done_o(done), .fail_o(fail)
  );

  function automatic int exp_rises(int k);
    return (k < MAXP) ? k + 1 : MAXP;
  endfunction

  function automatic bit exp_ok(int k);
    return k < MAXP;
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(int k, bit poke);
    int rises = 0, starts = 0, viol = 0;
    int t_f1 = -1, t_r1 = -1, t_f2 = -1, t_st = -1, t_hold = -1;
    bit prev_scl = 1'b1, prev_sda = 1'b0, got_done = 1'b0, got_fail = 1'b0;
    int quiet = 0;
    tgt_k = k;
    falls_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int idx = 0; idx < 3000; idx++) begin
      start = poke && (idx == 20);
      if (done || fail) begin
        got_done = done;
        got_fail = fail;
        break;
      end
      if (scl_line && !prev_scl) begin
        rises++;
        if (rises == 1) t_r1 = idx;
      end
      if (!scl_line && prev_scl) begin
        falls_cnt++;
        if (falls_cnt == 1) t_f1 = idx;
        if (falls_cnt == 2) t_f2 = idx;
        if (t_st >= 0 && t_hold < 0) t_hold = idx - t_st;
      end
      if (scl_line && prev_scl && (sda_line != prev_sda)) begin
        if (!sda_line) begin starts++; t_st = idx; end
        else viol++;
      end
      prev_scl = scl_line;
      prev_sda = sda_line;
      @(negedge clk);
    end
    start = 1'b0;
    check(got_done || got_fail, "R9 watchdog/outcome", 0, 1);
    check(got_done == exp_ok(k), "R4/R6 done outcome", got_done, exp_ok(k));
    check(got_fail == !exp_ok(k), "R6 fail outcome", got_fail, !exp_ok(k));
    check(rises == exp_rises(k), poke ? "R8 pulses with mid-run trigger" : "R2 pulse count",
          rises, exp_rises(k));
    check(viol == 0, "R5 data change with clock high", viol, 0);
    check(starts == (exp_ok(k) ? 1 : 0), "R3 start conditions", starts, exp_ok(k) ? 1 : 0);
    check(t_r1 - t_f1 == HALF, "R1 low phase", t_r1 - t_f1, HALF);
    if (k >= 1) check(t_f2 - t_r1 == HALF, "R1 high phase", t_f2 - t_r1, HALF);
    if (exp_ok(k)) check(t_hold == HALF, "R3 start hold", t_hold, HALF);
    if (got_fail) check(!scl_pull && !sda_pull, "R6 lines released", {scl_pull, sda_pull}, 0);
    for (int i = 0; i < 3 * HALF; i++) begin
      @(negedge clk);
      if (scl_pull || sda_pull || done || fail) quiet++;
    end
    check(quiet == 0, "R9/R7 quiet after end", quiet, 0);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!scl_pull && !sda_pull && !done && !fail, "R7 reset state",
          {scl_pull, sda_pull, done, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!scl_pull && !sda_pull, "R7 idle after reset", {scl_pull, sda_pull}, 0);
    run_case(0, 1'b0);
    run_case(1, 1'b1);
    run_case(MAXP - 1, 1'b0);
    run_case(MAXP, 1'b1);
    run_case(MAXP + 3, 1'b0);
    for (int n = 0; n < 30; n++) run_case(int'($urandom_range(0, 12)), bit'($urandom_range(0, 1)));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule